// File: doc/BRIEF.md
# Stepper Drive Command Interface

This block is the digital front end of a stepper power stage. It takes a step pulse, a rotation sense, an enable request, an external gate, a current-blanking input and a fault flag. All of them are asynchronous, and it synchronizes each one before use. It produces one-clock step strobes with a matching direction flag, a wrapping microstep phase index, an active-low ready status and a phase-current enable.

An enable request starts a power-up timer. When the timer expires the block reports ready and energizes the phases. Step edges count only while the block is ready and the gate is high. Edges that arrive at any other time are discarded; they are not held for later. A fault drops ready and keeps it dropped until enable is taken away and asserted again, and the new assertion runs the whole delay once more. The blanking input gates phase current independently of stepping, so a duty-cycled waveform on it sets the average current.

Top module: `stepper_cmd_if`

## Requirements
- R1: While rst_ni is low, step_o=0, dir_o=0, phase_o=0, ready_no=1 and phase_en_o=0.
- R2: Each rising edge of step_i that is accepted gives exactly one step_o pulse, one clock wide. The pulse is high in the third clock edge after the edge where step_i is first seen high.
- R3: dir_o goes out together with each strobe and carries dir_i as sampled on the same edge as step_i. A value of 0 means clockwise and 1 means counterclockwise.
- R4: enable_i stays high for READY_CYCLES clock edges after its two-flop synchronizer. ready_no then goes low, which is READY_CYCLES+2 edges after enable_i is first sampled high. When enable_i goes low, the timer clears and ready_no returns high.
- R5: A high fault_i drives ready_no high. ready_no stays high, even after fault_i clears, until enable_i goes low and then high again. The full delay then runs again.
- R6: phase_o counts up modulo PHASE_N on each accepted clockwise step and down on each accepted counterclockwise step. It goes to 0 one edge after ready is lost and stays at 0 while the block is not ready.
- R7: phase_en_o is 1 only while the block is ready and the synchronized pwm_i is 0. A high pwm_i therefore blanks current even at standstill.
- R8: A step edge seen while the block is not ready or gate_i is low makes no strobe and leaves phase_o unchanged. It is also never delivered later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Step pulse, rising edge requests a step |
| dir_i | input | 1 | Rotation sense, 0 clockwise, 1 counterclockwise |
| enable_i | input | 1 | Power stage enable request |
| gate_i | input | 1 | External step gate |
| pwm_i | input | 1 | Current blanking, high switches phase current off |
| fault_i | input | 1 | Power stage fault |
| step_o | output | 1 | One-clock accepted step strobe |
| dir_o | output | 1 | Direction accompanying the strobe |
| phase_o | output | PW | Microstep phase index, PW = $clog2(PHASE_N) |
| ready_no | output | 1 | Ready status, low when ready |
| phase_en_o | output | 1 | Phase current enable |

## Verification
The step input is driven with slow pulses, with back-to-back one-cycle pulses, and with pulses during the enable delay, while the gate is low and while a fault is latched. These separate correct edge detection from dropped or queued edges. Runs of clockwise and counterclockwise steps cross the modulo boundary both ways, which exposes wrap errors. Enable is aborted partway through the count and after a fault, and this shows whether the timer really restarts. A per-clock reference model checks the exact ready cycle, and the blanking input is toggled both while ready and while not ready.

// File: rtl/stepdrv_pkg.sv
package stepdrv_pkg;
  typedef struct packed {
    logic fault;
    logic pwm;
    logic gate;
    logic enable;
    logic dir;
    logic step;
  } drv_in_t;
  localparam int unsigned DRV_IN_W = $bits(drv_in_t);
endpackage

// File: rtl/stepdrv_sync.sv
module stepdrv_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end
  assign q_o = sync_q;
endmodule

// File: rtl/stepdrv_ready.sv
module stepdrv_ready #(
  parameter int unsigned READY_CYCLES = 100_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fault_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(READY_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(READY_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          lat_q, rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
      rdy_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
      rdy_q <= 1'b0;
    end else if (fault_i) begin
      cnt_q <= '0;
      lat_q <= 1'b1;
      rdy_q <= 1'b0;
    end else if (!lat_q && !rdy_q) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        rdy_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
  assign ready_o = rdy_q;

  p_en_low_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!rdy_q && cnt_q == '0));
  p_fault_drops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fault_i) |=> (!rdy_q && lat_q));
  p_latch_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && en_i) |=> !rdy_q);
endmodule

// File: rtl/stepdrv_phase.sv
module stepdrv_phase #(
  parameter int unsigned PHASE_N = 200,
  localparam int unsigned PW = $clog2(PHASE_N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rdy_i,
  input  logic          step_i,
  input  logic          ccw_i,
  output logic [PW-1:0] phase_o
);
  localparam logic [PW-1:0] PH_MAX = PW'(PHASE_N - 1);
  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ph_q <= '0;
    else if (!rdy_i)      ph_q <= '0;
    else if (step_i) begin
      if (ccw_i) ph_q <= (ph_q == '0) ? PH_MAX : ph_q - 1'b1;
      else       ph_q <= (ph_q == PH_MAX) ? '0 : ph_q + 1'b1;
    end
  end
  assign phase_o = ph_q;

  p_zero_unready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_i |=> ph_q == '0);
  p_wrap_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_i && step_i && !ccw_i && ph_q == PH_MAX) |=> ph_q == '0);
  p_wrap_down_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_i && step_i && ccw_i && ph_q == '0) |=> ph_q == PH_MAX);
endmodule

// File: rtl/stepper_cmd_if.sv
module stepper_cmd_if
  import stepdrv_pkg::*;
#(
  parameter int unsigned READY_CYCLES = 100_000_000,
  parameter int unsigned PHASE_N      = 200,
  localparam int unsigned PW = $clog2(PHASE_N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          dir_i,
  input  logic          enable_i,
  input  logic          gate_i,
  input  logic          pwm_i,
  input  logic          fault_i,
  output logic          step_o,
  output logic          dir_o,
  output logic [PW-1:0] phase_o,
  output logic          ready_no,
  output logic          phase_en_o
);
  drv_in_t raw, syn;
  logic    step_prev_q, rise, accept, rdy;
  logic    step_q, dir_q;

  assign raw = '{fault: fault_i, pwm: pwm_i, gate: gate_i,
                 enable: enable_i, dir: dir_i, step: step_i};

  stepdrv_sync #(.W(DRV_IN_W)) i_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (raw), .q_o (syn)
  );

  stepdrv_ready #(.READY_CYCLES(READY_CYCLES)) i_ready (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (syn.enable),
    .fault_i (syn.fault), .ready_o (rdy)
  );

  assign rise   = syn.step & ~step_prev_q;
  assign accept = rise & rdy & syn.gate;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_prev_q <= 1'b0;
      step_q      <= 1'b0;
      dir_q       <= 1'b0;
    end else begin
      step_prev_q <= syn.step;
      step_q      <= accept;
      dir_q       <= syn.dir;
    end
  end

  stepdrv_phase #(.PHASE_N(PHASE_N)) i_phase (
    .clk_i (clk_i), .rst_ni (rst_ni), .rdy_i (rdy),
    .step_i (accept), .ccw_i (syn.dir), .phase_o (phase_o)
  );

  assign step_o     = step_q;
  assign dir_o      = dir_q;
  assign ready_no   = ~rdy;
  assign phase_en_o = rdy & ~syn.pwm;

  p_strobe_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);
  p_strobe_needs_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_o) |-> $past(rdy));
  p_blank_when_unready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_no |-> !phase_en_o);
endmodule

// File: tb/test_stepper_cmd_if.sv
module test_stepper_cmd_if;
  localparam int RC = 24;
  localparam int N  = 6;
  localparam int PW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic step = 0, dir = 0, en = 0, gate = 0, pwm = 0, fault = 0;
  logic step_o, dir_o, ready_no, phase_en_o;
  logic [PW-1:0] phase_o;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stepper_cmd_if #(.READY_CYCLES(RC), .PHASE_N(N)) i_stepper_cmd_if (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .dir_i(dir), .enable_i(en),
    .gate_i(gate), .pwm_i(pwm), .fault_i(fault), .step_o(step_o), .dir_o(dir_o),
    .phase_o(phase_o), .ready_no(ready_no), .phase_en_o(phase_en_o));

  // reference model: inputs delayed two edges, then behavioural state
  int s1[6], s2[6], sprev;
  int m_step, m_dir, m_ph, m_rdy, m_cnt, m_lat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (s1[i]) begin s1[i] = 0; s2[i] = 0; end
      sprev = 0; m_step = 0; m_dir = 0; m_ph = 0; m_rdy = 0; m_cnt = 0; m_lat = 0;
    end else begin
      int acc;
      acc = (s2[0] == 1 && sprev == 0 && m_rdy == 1 && s2[3] == 1) ? 1 : 0;
      m_step = acc;
      m_dir  = s2[1];
      if (m_rdy == 0) m_ph = 0;
      else if (acc == 1) m_ph = (s2[1] == 1) ? (m_ph + N - 1) % N : (m_ph + 1) % N;
      if (s2[2] == 0) begin m_cnt = 0; m_rdy = 0; m_lat = 0; end
      else if (s2[5] == 1) begin m_cnt = 0; m_rdy = 0; m_lat = 1; end
      else if (m_lat == 0 && m_rdy == 0) begin
        m_cnt++;
        if (m_cnt == RC) m_rdy = 1;
      end
      sprev = s2[0];
      s2 = s1;
      s1[0] = step; s1[1] = dir; s1[2] = en; s1[3] = gate; s1[4] = pwm; s1[5] = fault;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk("R2 step_o", int'(step_o), m_step);
      if (step_o) chk("R3 dir_o", int'(dir_o), m_dir);
      chk("R6 phase_o", int'(phase_o), m_ph);
      chk("R4/R5 ready_no", int'(ready_no), 1 - m_rdy);
      chk("R7 phase_en_o", int'(phase_en_o), (m_rdy == 1 && s2[4] == 0) ? 1 : 0);
    end
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  int n_strobes = 0;
  always @(negedge clk) if (rst_n && step_o) n_strobes++;

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    step = 1; wait_n(hi); step = 0; wait_n(lo);
  endtask

  initial begin
    wait_n(3);
    chk("R1 step_o", int'(step_o), 0);
    chk("R1 dir_o", int'(dir_o), 0);
    chk("R1 phase_o", int'(phase_o), 0);
    chk("R1 ready_no", int'(ready_no), 1);
    chk("R1 phase_en_o", int'(phase_en_o), 0);
    rst_n = 1;
    gate = 1;
    wait_n(3);
    // R8: steps before enable
    repeat (3) pulse(2, 3);
    chk("R8 no strobe while disabled", n_strobes, 0);
    // R4: exact ready latency
    en = 1;
    wait_n(RC + 1);
    chk("R4 not yet ready", int'(ready_no), 1);
    wait_n(1);
    chk("R4 ready after delay", int'(ready_no), 0);
    // R2/R6: clockwise wrap
    dir = 0;
    repeat (8) pulse(3, 4);
    wait_n(3);
    chk("R6 cw wrap", int'(phase_o), 2);
    chk("R2 one strobe per edge", n_strobes, 8);
    // R3/R6: counterclockwise wrap
    dir = 1;
    repeat (5) pulse(2, 3);
    wait_n(3);
    chk("R6 ccw wrap", int'(phase_o), 3);
    // R8: gate low
    gate = 0;
    repeat (3) pulse(2, 2);
    wait_n(3);
    chk("R8 gated steps dropped", int'(phase_o), 3);
    gate = 1;
    wait_n(3);
    chk("R8 not delivered later", n_strobes, 13);
    // R2: fast pulses, alternating direction
    for (int i = 0; i < 6; i++) begin dir = i[0]; pulse(1, 1); end
    wait_n(4);
    chk("R2 fast pulses", n_strobes, 19);
    // R7: blanking toggled
    for (int i = 0; i < 8; i++) begin pwm = ~pwm; wait_n(1 + i % 3); end
    pwm = 1; wait_n(3);
    chk("R7 blanked at standstill", int'(phase_en_o), 0);
    pwm = 0; wait_n(3);
    // R5: fault latch
    fault = 1; wait_n(1); fault = 0;
    wait_n(RC + 10);
    chk("R5 fault latched", int'(ready_no), 1);
    chk("R6 phase cleared", int'(phase_o), 0);
    repeat (2) pulse(2, 2);
    pwm = 1; wait_n(2); pwm = 0;
    en = 0; wait_n(4); en = 1;
    wait_n(RC + 1);
    chk("R5 full delay restart", int'(ready_no), 1);
    wait_n(1);
    chk("R5 ready after re-enable", int'(ready_no), 0);
    // R4: abort mid-count
    en = 0; wait_n(4); en = 1; wait_n(RC / 2); en = 0; wait_n(4); en = 1;
    wait_n(RC + 1);
    chk("R4 timer restarted", int'(ready_no), 1);
    wait_n(1);
    chk("R4 ready after restart", int'(ready_no), 0);
    dir = 0;
    repeat (4) pulse(2, 2);
    wait_n(4);
    chk("R6 count after restart", int'(phase_o), 4);
    finish_run();
  end
endmodule